// File: doc/BRIEF.md
# Sliding Window Jet Finder

This block searches a small two-dimensional grid of calorimeter jet elements for jets, once per bunch crossing, in a fully pipelined way. Every grid bin brings an electromagnetic and a hadronic energy, and the two are added to form the jet-element energy. Candidate regions of interest are 2x2 groups of elements, and the window steps one element at a time in both grid directions. Only a candidate that is a disambiguated local maximum among its eight neighbouring candidates becomes a jet, so a single deposit produces one region of interest even though it sits inside four overlapping candidates.

Finding the jet and measuring it use different windows. Once a region of interest is found, its energy is summed over a 2x2, 3x3 or 4x4 window chosen by a run-time setting. That energy is compared against eight programmable thresholds, giving one saturating multiplicity count per threshold, and the first maxima in scan order are listed with their core-relative positions and energies. The input grid is the core plus a ring of environment cells (one row or column before the core, two after, in each direction), which supplies the neighbours that the comparisons and the larger windows need. Results are reported for core positions only. The window setting and thresholds are sampled together with each grid and travel with it, so a new grid with its own configuration can be presented on every clock cycle.

Top module: `slide_jet_finder`

## Requirements
- R1: Each bin's jet-element energy is the unsigned sum of its electromagnetic and hadronic inputs, kept at one bit wider than the inputs so that two full-scale inputs do not overflow.
- R2: The grid is GxG with G = CORE+3; bin (e, p) occupies bits [(p*G+e)*16 +: 16] of each energy bus. Core bins are e, p in 1..CORE. A candidate anchored at bin (e, p) is the sum of bins e..e+1 by p..p+1.
- R3: A candidate is a maximum only if its sum is nonzero, strictly greater than each neighbouring candidate with a larger p (or the same p and a larger e), and greater than or equal to each of the other neighbours; two maxima are therefore never adjacent.
- R4: Only candidates anchored on core bins are reported; a maximum anchored in the environment ring produces no jet and no count.
- R5: The window setting selects the jet energy: 0 gives the 2x2 candidate sum, 1 the 3x3 sum over e-1..e+1 by p-1..p+1, 2 and 3 the 4x4 sum over e-1..e+2 by p-1..p+2.
- R6: Multiplicity k (bits [3k +: 3] of the count bus) counts maxima whose jet energy is strictly greater than threshold k (bits [20k +: 20] of the threshold bus), and saturates at 7.
- R7: The jet list holds the first MAX_JETS maxima in ascending core index (e-1) + CORE*(p-1); slot s uses valid bit s, position bits [6s +: 6] and energy bits [21s +: 21]; valid slots are packed from slot 0.
- R8: A grid presented with its valid bit in one cycle produces its results with the output valid bit four cycles later; grids may arrive on consecutive cycles, each evaluated with the configuration presented alongside it.
- R9: While reset is asserted, the output valid bit, all multiplicities and all list valid bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A grid is present on the energy buses |
| in_em | input | (CORE+3)^2*16 | Electromagnetic energy per bin, flattened |
| in_had | input | (CORE+3)^2*16 | Hadronic energy per bin, flattened |
| cfg_win | input | 2 | Jet energy window select |
| cfg_thr | input | 8*20 | Eight jet energy thresholds |
| out_valid | output | 1 | Results for a grid are present |
| out_mult | output | 8*3 | Saturating jet count per threshold |
| out_jet_valid | output | MAX_JETS | Valid bit per list slot |
| out_jet_pos | output | MAX_JETS*6 | Core-relative position per list slot |
| out_jet_et | output | MAX_JETS*21 | Jet energy per list slot |

## Verification
An empty grid and isolated single deposits separate the nonzero rule and the anchoring of a maximum from plain summation, while full-scale electromagnetic plus hadronic inputs expose any lost carry. Two equal neighbouring bins, deposits in the environment ring and a lattice of nine separated peaks tell the tie-breaking order, the core-only reporting and the count saturation and list truncation apart. One grid replayed under all four window settings, and thresholds set one below, equal to and one above a known energy, distinguish window placement and the strict comparison. A long run of random sparse grids with a new window setting and thresholds every cycle shows that configuration stays attached to its own grid through the pipeline.

// File: rtl/jetf_pkg.sv
package jetf_pkg;

    // environment ring: one bin before the core, two after, in each direction
    localparam int BORDER_LO = 1;
    localparam int BORDER_HI = 2;

    typedef enum logic [1:0] {
        WIN_2X2  = 2'd0,
        WIN_3X3  = 2'd1,
        WIN_4X4  = 2'd2,
        WIN_4X4B = 2'd3
    } win_sel_e;

    // offset of the first window bin relative to the candidate anchor
    function automatic int win_first(input win_sel_e s);
        return (s == WIN_2X2) ? 0 : -1;
    endfunction

    // number of bins along each side of the window
    function automatic int win_span(input win_sel_e s);
        case (s)
            WIN_2X2: return 2;
            WIN_3X3: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic int sat_limit(input int n, input int lim);
        return (n > lim) ? lim : n;
    endfunction

endpackage

// File: rtl/jetf_elem_stage.sv
module jetf_elem_stage
    import jetf_pkg::*;
#(
    parameter int G      = 11,
    parameter int E_W    = 16,
    parameter int N_THR  = 8,
    parameter int THR_W  = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        i_valid,
    input  logic [G*G*E_W-1:0]          i_em,
    input  logic [G*G*E_W-1:0]          i_had,
    input  win_sel_e                    i_win,
    input  logic [N_THR*THR_W-1:0]      i_thr,
    output logic                        o_valid,
    output logic [G*G*(E_W+1)-1:0]      o_elem,
    output win_sel_e                    o_win,
    output logic [N_THR*THR_W-1:0]      o_thr
);
    localparam int ELEM_W = E_W + 1;
    localparam int NCELL  = G * G;

    logic [ELEM_W-1:0] sum_c [NCELL];

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        assign sum_c[c] = ELEM_W'(i_em[c*E_W +: E_W]) + ELEM_W'(i_had[c*E_W +: E_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) o_valid <= 1'b0;
        else     o_valid <= i_valid;
    end

    always_ff @(posedge clk) begin
        for (int c = 0; c < NCELL; c++) o_elem[c*ELEM_W +: ELEM_W] <= sum_c[c];
        o_win <= i_win;
        o_thr <= i_thr;
    end

    // R1: a registered element equals the sum of the inputs captured one cycle earlier
    for (genvar c = 0; c < NCELL; c += G + 1) begin : g_chk
        p_elem_sum_r1: assert property (@(posedge clk) disable iff (rst)
            $past(i_valid) |-> (o_elem[c*ELEM_W +: ELEM_W] ==
                ELEM_W'($past(i_em[c*E_W +: E_W])) + ELEM_W'($past(i_had[c*E_W +: E_W]))));
    end

endmodule

// File: rtl/jetf_window_stage.sv
module jetf_window_stage
    import jetf_pkg::*;
#(
    parameter int CORE   = 8,
    parameter int ELEM_W = 17,
    parameter int N_THR  = 8,
    parameter int THR_W  = 20
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   i_valid,
    input  logic [(CORE+3)*(CORE+3)*ELEM_W-1:0]    i_elem,
    input  win_sel_e                               i_win,
    input  logic [N_THR*THR_W-1:0]                 i_thr,
    output logic                                   o_valid,
    output logic [(CORE+2)*(CORE+2)*(ELEM_W+2)-1:0] o_roi,
    output logic [CORE*CORE*(ELEM_W+4)-1:0]        o_w3,
    output logic [CORE*CORE*(ELEM_W+4)-1:0]        o_w4,
    output win_sel_e                               o_win,
    output logic [N_THR*THR_W-1:0]                 o_thr
);
    localparam int G     = CORE + BORDER_LO + BORDER_HI;
    localparam int R     = CORE + 2;
    localparam int ROI_W = ELEM_W + 2;
    localparam int JET_W = ELEM_W + 4;

    logic [ELEM_W-1:0] el    [G][G];
    logic [ROI_W-1:0]  roi_c [R][R];
    logic [JET_W-1:0]  w3_c  [CORE][CORE];
    logic [JET_W-1:0]  w4_c  [CORE][CORE];

    for (genvar gp = 0; gp < G; gp++) begin : g_row
        for (genvar ge = 0; ge < G; ge++) begin : g_col
            assign el[gp][ge] = i_elem[(gp*G+ge)*ELEM_W +: ELEM_W];
        end
    end

    // candidate sums: anchor index equals grid index, anchors 0..CORE+1
    for (genvar ap = 0; ap < R; ap++) begin : g_roi_row
        for (genvar ae = 0; ae < R; ae++) begin : g_roi_col
            assign roi_c[ap][ae] = ROI_W'(el[ap][ae])   + ROI_W'(el[ap][ae+1]) +
                                   ROI_W'(el[ap+1][ae]) + ROI_W'(el[ap+1][ae+1]);
        end
    end

    // larger windows for core anchors only
    for (genvar cp = 0; cp < CORE; cp++) begin : g_win_row
        for (genvar ce = 0; ce < CORE; ce++) begin : g_win_col
            localparam int AE = ce + BORDER_LO;
            localparam int AP = cp + BORDER_LO;
            logic [JET_W-1:0] acc3, acc4;
            always_comb begin
                acc3 = '0;
                for (int dy = 0; dy < win_span(WIN_3X3); dy++)
                    for (int dx = 0; dx < win_span(WIN_3X3); dx++)
                        acc3 = acc3 + JET_W'(el[AP+win_first(WIN_3X3)+dy][AE+win_first(WIN_3X3)+dx]);
                acc4 = '0;
                for (int dy = 0; dy < win_span(WIN_4X4); dy++)
                    for (int dx = 0; dx < win_span(WIN_4X4); dx++)
                        acc4 = acc4 + JET_W'(el[AP+win_first(WIN_4X4)+dy][AE+win_first(WIN_4X4)+dx]);
            end
            assign w3_c[cp][ce] = acc3;
            assign w4_c[cp][ce] = acc4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) o_valid <= 1'b0;
        else     o_valid <= i_valid;
    end

    always_ff @(posedge clk) begin
        for (int ap = 0; ap < R; ap++)
            for (int ae = 0; ae < R; ae++)
                o_roi[(ap*R+ae)*ROI_W +: ROI_W] <= roi_c[ap][ae];
        for (int cp = 0; cp < CORE; cp++)
            for (int ce = 0; ce < CORE; ce++) begin
                o_w3[(cp*CORE+ce)*JET_W +: JET_W] <= w3_c[cp][ce];
                o_w4[(cp*CORE+ce)*JET_W +: JET_W] <= w4_c[cp][ce];
            end
        o_win <= i_win;
        o_thr <= i_thr;
    end

    // R5: a 4x4 window never holds less energy than the 3x3 window it contains
    for (genvar i = 0; i < CORE*CORE; i++) begin : g_chk
        p_win_nested_r5: assert property (@(posedge clk) disable iff (rst)
            o_valid |-> (o_w4[i*JET_W +: JET_W] >= o_w3[i*JET_W +: JET_W]));
    end

endmodule

// File: rtl/jetf_peak_stage.sv
module jetf_peak_stage
    import jetf_pkg::*;
#(
    parameter int CORE   = 8,
    parameter int ELEM_W = 17,
    parameter int N_THR  = 8,
    parameter int THR_W  = 20
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    i_valid,
    input  logic [(CORE+2)*(CORE+2)*(ELEM_W+2)-1:0] i_roi,
    input  logic [CORE*CORE*(ELEM_W+4)-1:0]         i_w3,
    input  logic [CORE*CORE*(ELEM_W+4)-1:0]         i_w4,
    input  win_sel_e                                i_win,
    input  logic [N_THR*THR_W-1:0]                  i_thr,
    output logic                                    o_valid,
    output logic [CORE*CORE-1:0]                    o_peak,
    output logic [CORE*CORE*(ELEM_W+4)-1:0]         o_et,
    output logic [N_THR*THR_W-1:0]                  o_thr
);
    localparam int R     = CORE + 2;
    localparam int ROI_W = ELEM_W + 2;
    localparam int JET_W = ELEM_W + 4;
    localparam int NPOS  = CORE * CORE;

    logic [ROI_W-1:0] roi_a  [R][R];
    logic             peak_c [NPOS];
    logic [JET_W-1:0] et_c   [NPOS];

    for (genvar ap = 0; ap < R; ap++) begin : g_row
        for (genvar ae = 0; ae < R; ae++) begin : g_col
            assign roi_a[ap][ae] = i_roi[(ap*R+ae)*ROI_W +: ROI_W];
        end
    end

    for (genvar cp = 0; cp < CORE; cp++) begin : g_pk_row
        for (genvar ce = 0; ce < CORE; ce++) begin : g_pk_col
            localparam int IDX = cp*CORE + ce;
            localparam int AE  = ce + BORDER_LO;
            localparam int AP  = cp + BORDER_LO;
            logic [ROI_W-1:0] own, nb;
            logic             later, keep;
            always_comb begin
                own  = roi_a[AP][AE];
                keep = (own != '0);
                nb   = '0;
                later = 1'b0;
                for (int dp = -1; dp <= 1; dp++)
                    for (int de = -1; de <= 1; de++)
                        if (dp != 0 || de != 0) begin
                            nb    = roi_a[AP+dp][AE+de];
                            later = (dp > 0) || (dp == 0 && de > 0);
                            if (later ? (own <= nb) : (own < nb)) keep = 1'b0;
                        end
            end
            assign peak_c[IDX] = keep;

            always_comb begin
                case (i_win)
                    WIN_2X2: et_c[IDX] = JET_W'(own);
                    WIN_3X3: et_c[IDX] = i_w3[IDX*JET_W +: JET_W];
                    default: et_c[IDX] = i_w4[IDX*JET_W +: JET_W];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_peak  <= '0;
        end else begin
            o_valid <= i_valid;
            for (int i = 0; i < NPOS; i++) o_peak[i] <= peak_c[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPOS; i++) o_et[i*JET_W +: JET_W] <= et_c[i];
        o_thr <= i_thr;
    end

    // R3: disambiguation never leaves two maxima side by side
    for (genvar cp = 0; cp < CORE; cp++) begin : g_adj_row
        for (genvar ce = 0; ce < CORE; ce++) begin : g_adj_col
            if (ce < CORE-1) begin : g_eta
                p_no_adjacent_r3: assert property (@(posedge clk) disable iff (rst)
                    o_valid |-> !(o_peak[cp*CORE+ce] && o_peak[cp*CORE+ce+1]));
            end
            if (cp < CORE-1) begin : g_phi
                p_no_adjacent_r3: assert property (@(posedge clk) disable iff (rst)
                    o_valid |-> !(o_peak[cp*CORE+ce] && o_peak[(cp+1)*CORE+ce]));
            end
        end
    end

endmodule

// File: rtl/jetf_count_stage.sv
module jetf_count_stage
    import jetf_pkg::*;
#(
    parameter int CORE     = 8,
    parameter int JET_W    = 21,
    parameter int N_THR    = 8,
    parameter int THR_W    = 20,
    parameter int CNT_W    = 3,
    parameter int MAX_JETS = 8,
    parameter int PW       = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        i_valid,
    input  logic [CORE*CORE-1:0]        i_peak,
    input  logic [CORE*CORE*JET_W-1:0]  i_et,
    input  logic [N_THR*THR_W-1:0]      i_thr,
    output logic                        o_valid,
    output logic [N_THR*CNT_W-1:0]      o_mult,
    output logic [MAX_JETS-1:0]         o_jv,
    output logic [MAX_JETS*PW-1:0]      o_pos,
    output logic [MAX_JETS*JET_W-1:0]   o_et
);
    localparam int NPOS    = CORE * CORE;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [N_THR*CNT_W-1:0]    mult_c;
    logic [MAX_JETS-1:0]       jv_c;
    logic [MAX_JETS*PW-1:0]    pos_c;
    logic [MAX_JETS*JET_W-1:0] et_c;

    always_comb begin
        int n;
        for (int k = 0; k < N_THR; k++) begin
            n = 0;
            for (int i = 0; i < NPOS; i++)
                if (i_peak[i] && (i_et[i*JET_W +: JET_W] > JET_W'(i_thr[k*THR_W +: THR_W])))
                    n++;
            mult_c[k*CNT_W +: CNT_W] = CNT_W'(sat_limit(n, CNT_MAX));
        end
    end

    always_comb begin
        int slot;
        slot  = 0;
        jv_c  = '0;
        pos_c = '0;
        et_c  = '0;
        for (int i = 0; i < NPOS; i++)
            if (i_peak[i] && slot < MAX_JETS) begin
                jv_c[slot]              = 1'b1;
                pos_c[slot*PW +: PW]    = PW'(i);
                et_c[slot*JET_W +: JET_W] = i_et[i*JET_W +: JET_W];
                slot++;
            end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_mult  <= '0;
            o_jv    <= '0;
            o_pos   <= '0;
            o_et    <= '0;
        end else begin
            o_valid <= i_valid;
            o_mult  <= mult_c;
            o_jv    <= jv_c;
            o_pos   <= pos_c;
            o_et    <= et_c;
        end
    end

    // R7: list slots fill from slot 0 and in ascending position
    for (genvar s = 0; s < MAX_JETS-1; s++) begin : g_list
        p_list_packed_r7: assert property (@(posedge clk) disable iff (rst)
            o_jv[s+1] |-> o_jv[s]);
        p_list_order_r7: assert property (@(posedge clk) disable iff (rst)
            o_jv[s+1] |-> (o_pos[(s+1)*PW +: PW] > o_pos[s*PW +: PW]));
    end

    // R6: any nonzero count implies at least one listed jet
    p_mult_has_list_r6: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_mult != '0) |-> o_jv[0]);

endmodule

// File: rtl/slide_jet_finder.sv
module slide_jet_finder
    import jetf_pkg::*;
#(
    parameter int CORE     = 8,
    parameter int E_W      = 16,
    parameter int N_THR    = 8,
    parameter int THR_W    = 20,
    parameter int CNT_W    = 3,
    parameter int MAX_JETS = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    input  logic [(CORE+3)*(CORE+3)*E_W-1:0]      in_em,
    input  logic [(CORE+3)*(CORE+3)*E_W-1:0]      in_had,
    input  logic [1:0]                            cfg_win,
    input  logic [N_THR*THR_W-1:0]                cfg_thr,
    output logic                                  out_valid,
    output logic [N_THR*CNT_W-1:0]                out_mult,
    output logic [MAX_JETS-1:0]                   out_jet_valid,
    output logic [MAX_JETS*$clog2(CORE*CORE)-1:0] out_jet_pos,
    output logic [MAX_JETS*(E_W+5)-1:0]           out_jet_et
);
    localparam int G      = CORE + BORDER_LO + BORDER_HI;
    localparam int R      = CORE + 2;
    localparam int ELEM_W = E_W + 1;
    localparam int ROI_W  = ELEM_W + 2;
    localparam int JET_W  = ELEM_W + 4;
    localparam int PW     = $clog2(CORE*CORE);

    logic                          s1_valid, s2_valid, s3_valid;
    logic [G*G*ELEM_W-1:0]         s1_elem;
    win_sel_e                      s1_win, s2_win;
    logic [N_THR*THR_W-1:0]        s1_thr, s2_thr, s3_thr;
    logic [R*R*ROI_W-1:0]          s2_roi;
    logic [CORE*CORE*JET_W-1:0]    s2_w3, s2_w4, s3_et;
    logic [CORE*CORE-1:0]          s3_peak;

    jetf_elem_stage #(.G(G), .E_W(E_W), .N_THR(N_THR), .THR_W(THR_W)) u_elem (
        .clk(clk), .rst(rst), .i_valid(in_valid), .i_em(in_em), .i_had(in_had),
        .i_win(win_sel_e'(cfg_win)), .i_thr(cfg_thr),
        .o_valid(s1_valid), .o_elem(s1_elem), .o_win(s1_win), .o_thr(s1_thr)
    );

    jetf_window_stage #(.CORE(CORE), .ELEM_W(ELEM_W), .N_THR(N_THR), .THR_W(THR_W)) u_window (
        .clk(clk), .rst(rst), .i_valid(s1_valid), .i_elem(s1_elem),
        .i_win(s1_win), .i_thr(s1_thr),
        .o_valid(s2_valid), .o_roi(s2_roi), .o_w3(s2_w3), .o_w4(s2_w4),
        .o_win(s2_win), .o_thr(s2_thr)
    );

    jetf_peak_stage #(.CORE(CORE), .ELEM_W(ELEM_W), .N_THR(N_THR), .THR_W(THR_W)) u_peak (
        .clk(clk), .rst(rst), .i_valid(s2_valid), .i_roi(s2_roi),
        .i_w3(s2_w3), .i_w4(s2_w4), .i_win(s2_win), .i_thr(s2_thr),
        .o_valid(s3_valid), .o_peak(s3_peak), .o_et(s3_et), .o_thr(s3_thr)
    );

    jetf_count_stage #(.CORE(CORE), .JET_W(JET_W), .N_THR(N_THR), .THR_W(THR_W),
                       .CNT_W(CNT_W), .MAX_JETS(MAX_JETS), .PW(PW)) u_count (
        .clk(clk), .rst(rst), .i_valid(s3_valid), .i_peak(s3_peak),
        .i_et(s3_et), .i_thr(s3_thr),
        .o_valid(out_valid), .o_mult(out_mult), .o_jv(out_jet_valid),
        .o_pos(out_jet_pos), .o_et(out_jet_et)
    );

    // cycles since reset, saturating, so the latency check never reaches before reset
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                    since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end

    // R8: output valid follows input valid by exactly four cycles
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R9: nothing valid leaves the block during reset
    p_reset_quiet_r9: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_jet_valid == '0 && out_mult == '0));

endmodule

// File: tb/slide_jet_finder_bench.sv
`timescale 1ns/1ps
module slide_jet_finder_bench;

    localparam int CORE  = 8;
    localparam int E_W   = 16;
    localparam int N_THR = 8;
    localparam int THR_W = 20;
    localparam int CNT_W = 3;
    localparam int MJ    = 8;
    localparam int G     = CORE + 3;
    localparam int JW    = E_W + 5;
    localparam int PW    = 6;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      in_valid = 1'b0;
    logic [G*G*E_W-1:0]        in_em = '0;
    logic [G*G*E_W-1:0]        in_had = '0;
    logic [1:0]                cfg_win = 2'd0;
    logic [N_THR*THR_W-1:0]    cfg_thr = '0;
    logic                      out_valid;
    logic [N_THR*CNT_W-1:0]    out_mult;
    logic [MJ-1:0]             out_jet_valid;
    logic [MJ*PW-1:0]          out_jet_pos;
    logic [MJ*JW-1:0]          out_jet_et;

    slide_jet_finder #(.CORE(CORE), .E_W(E_W), .N_THR(N_THR), .THR_W(THR_W),
                       .CNT_W(CNT_W), .MAX_JETS(MJ)) u_slide_jet_finder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_em(in_em), .in_had(in_had),
        .cfg_win(cfg_win), .cfg_thr(cfg_thr), .out_valid(out_valid), .out_mult(out_mult),
        .out_jet_valid(out_jet_valid), .out_jet_pos(out_jet_pos), .out_jet_et(out_jet_et)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [N_THR*CNT_W-1:0] mult;
        logic [MJ-1:0]          jv;
        logic [MJ*PW-1:0]       pos;
        logic [MJ*JW-1:0]       et;
        int                     cyc;
        string                  tag;
    } exp_t;

    exp_t q[$];
    int   em  [G][G];
    int   had [G][G];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    logic [N_THR*THR_W-1:0] thr_v;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int box(input int e0, input int p0, input int n);
        int s = 0;
        for (int p = p0; p < p0 + n; p++)
            for (int e = e0; e < e0 + n; e++)
                s += em[p][e] + had[p][e];
        return s;
    endfunction

    task automatic predict(input int win, output exp_t x);
        int cnt [N_THR];
        int slot;
        slot = 0;
        x.mult = '0; x.jv = '0; x.pos = '0; x.et = '0;
        for (int k = 0; k < N_THR; k++) cnt[k] = 0;
        for (int cp = 0; cp < CORE; cp++)
            for (int ce = 0; ce < CORE; ce++) begin
                int ge = ce + 1;
                int gp = cp + 1;
                int own = box(ge, gp, 2);
                bit ok = (own > 0);
                int en;
                for (int dp = -1; dp <= 1; dp++)
                    for (int de = -1; de <= 1; de++)
                        if (dp != 0 || de != 0) begin
                            int nb = box(ge + de, gp + dp, 2);
                            bit later = (dp > 0) || (dp == 0 && de > 0);
                            if (later ? !(own > nb) : !(own >= nb)) ok = 0;
                        end
                if (ok) begin
                    en = (win == 0) ? own : (win == 1) ? box(ge-1, gp-1, 3) : box(ge-1, gp-1, 4);
                    for (int k = 0; k < N_THR; k++)
                        if (en > int'(thr_v[k*THR_W +: THR_W])) cnt[k]++;
                    if (slot < MJ) begin
                        x.jv[slot] = 1'b1;
                        x.pos[slot*PW +: PW] = PW'(cp*CORE + ce);
                        x.et[slot*JW +: JW] = JW'(en);
                        slot++;
                    end
                end
            end
        for (int k = 0; k < N_THR; k++)
            x.mult[k*CNT_W +: CNT_W] = CNT_W'((cnt[k] > 7) ? 7 : cnt[k]);
    endtask

    task automatic clear_grid();
        for (int p = 0; p < G; p++)
            for (int e = 0; e < G; e++) begin
                em[p][e] = 0;
                had[p][e] = 0;
            end
    endtask

    task automatic set_thr_all(input int v);
        for (int k = 0; k < N_THR; k++) thr_v[k*THR_W +: THR_W] = THR_W'(v);
    endtask

    // driver: one grid per call, back to back
    task automatic send(input int win, input string tag);
        exp_t x;
        @(negedge clk);
        for (int p = 0; p < G; p++)
            for (int e = 0; e < G; e++) begin
                in_em[(p*G+e)*E_W +: E_W]  = E_W'(em[p][e]);
                in_had[(p*G+e)*E_W +: E_W] = E_W'(had[p][e]);
            end
        cfg_win  = 2'(win);
        cfg_thr  = thr_v;
        in_valid = 1'b1;
        predict(win, x);
        x.cyc = cyc;
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_em = '0;
            in_had = '0;
        end
    endtask

    // monitor: compares each result with the oldest expected item
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R8 unexpected output", 256'(out_valid), 256'(0));
            end else begin
                exp_t x;
                x = q.pop_front();
                chk(cyc - x.cyc == 4, {x.tag, " R8 latency"}, 256'(cyc - x.cyc), 256'(4));
                chk(out_mult == x.mult, {x.tag, " R6 multiplicity"}, 256'(out_mult), 256'(x.mult));
                chk(out_jet_valid == x.jv && out_jet_pos == x.pos, {x.tag, " R7 list positions"},
                    256'({out_jet_valid, out_jet_pos}), 256'({x.jv, x.pos}));
                chk(out_jet_et == x.et, {x.tag, " R7 list energies"}, 256'(out_jet_et), 256'(x.et));
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        thr_v = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && out_mult == '0 && out_jet_valid == '0, "R9 reset state",
            256'({out_valid, out_mult, out_jet_valid}), 256'(0));
        rst = 1'b0;
        idle(2);
        chk(!out_valid, "R9 idle after reset", 256'(out_valid), 256'(0));

        // empty grid: nonzero rule
        clear_grid(); set_thr_all(0);
        send(0, "R3 empty grid");

        // single deposit: anchoring
        clear_grid(); em[5][4] = 1000;
        send(0, "R2 single bin");
        clear_grid(); had[1][1] = 700;
        send(2, "R2 corner core bin");

        // full-scale em + had
        clear_grid(); em[4][5] = 65535; had[4][5] = 65535;
        set_thr_all(131069);
        send(0, "R1 full scale sum");

        // window select on one shaped grid
        clear_grid();
        em[4][4] = 5000;
        for (int d = -1; d <= 2; d++) begin
            em[3][4+d] += 10; em[6][4+d] += 7; had[4+d][3] += 3; had[4+d][6] += 5;
        end
        for (int k = 0; k < N_THR; k++) thr_v[k*THR_W +: THR_W] = THR_W'(5000 + 15*k);
        for (int w = 0; w < 4; w++) send(w, "R5 window select");

        // equal neighbours: tie order
        clear_grid(); set_thr_all(0);
        em[4][4] = 500; em[4][5] = 500;
        send(0, "R3 equal eta pair");
        clear_grid(); em[4][4] = 500; em[5][4] = 500;
        send(1, "R3 equal phi pair");

        // environment deposits
        clear_grid(); em[5][0] = 9000; had[10][10] = 9000; em[9][5] = 4000;
        send(2, "R4 environment only");

        // lattice of nine peaks: saturation and truncation
        clear_grid();
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++) em[1+3*j][1+3*i] = 100 + 10*(3*j+i);
        set_thr_all(0);
        thr_v[7*THR_W +: THR_W] = 155;
        send(0, "R6 saturation");

        // strict threshold comparison
        clear_grid(); em[4][4] = 3000; set_thr_all(0);
        thr_v[0 +: THR_W] = 2999; thr_v[THR_W +: THR_W] = 3000; thr_v[2*THR_W +: THR_W] = 3001;
        send(0, "R6 threshold edge");

        idle(6);

        // random sparse grids back to back, configuration changing every cycle
        for (int n = 0; n < 150; n++) begin
            clear_grid();
            for (int p = 0; p < G; p++)
                for (int e = 0; e < G; e++) begin
                    if ($urandom_range(0, 5) == 0) em[p][e] = $urandom_range(0, 65535);
                    if ($urandom_range(0, 5) == 0) had[p][e] = $urandom_range(0, 65535);
                end
            for (int k = 0; k < N_THR; k++) thr_v[k*THR_W +: THR_W] = THR_W'($urandom_range(0, 600000));
            send($urandom_range(0, 3), "R8 random stream");
        end
        idle(8);
        chk(q.size() == 0, "R8 all results delivered", 256'(q.size()), 256'(0));
        finish_run();
    end

endmodule